// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of an asynchronous parallel EEPROM and turns a stream of byte requests into correctly timed write strobes. The host offers one byte at a time with an address, a data value and a flag that marks the final byte of a page. The sequencer drives the memory's chip enable, write enable and output enable, plus the address bus and the data bus. It counts every setup, pulse and hold interval in system clock cycles, so one parameter set per clock rate and speed grade sets all the margins.

Chip enable stays low for a whole page. The write enable controls each byte. The memory restarts an internal byte-load timer on every write-enable rising edge and commits the page if that timer expires. For that reason the sequencer never lets the gap between strobes reach the window limit. If the host does not supply the next byte within a programmable margin below that limit, the sequencer closes the page on its own. After the final byte, or after such a timeout, it raises chip enable and waits out the internal write cycle. After reset it holds off every write for the power-up inhibit period.

Top module: `eep_page_writer`

## Requirements
- R1: During reset and for exactly TINH_CYC cycles after it is released, `req_ready` is 0, `busy` is 1, and `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1. `req_ready` first reads 1 on cycle TINH_CYC.
- R2: A byte is taken only in a cycle where both `req_start` and `req_ready` are 1. A `req_start` given while `req_ready` is 0 causes no strobe, either then or later.
- R3: Each byte that is taken produces exactly one `mem_we_n` low pulse lasting TWP_CYC cycles. The pulse carries that byte's address and data, and the pulses come in the order the bytes were taken.
- R4: `mem_addr` and `mem_dq` do not change while `mem_we_n` is low.
- R5: Within a page, the time from a `mem_we_n` rising edge to the next falling edge lies between BLC_MIN_CYC and WIN_MAX_CYC-WIN_MARGIN_CYC cycles. `req_ready` is 0 in the cycle after a rising edge. With the bench parameters it is 1 in the second cycle after that edge while the page is still open.
- R6: `mem_we_n` is low only while `mem_ce_n` is low, and `mem_ce_n` stays low from the first byte of a page to the end of the last strobe's hold.
- R7: When the byte carrying `req_last`=1 finishes, `mem_ce_n` rises THOLD_CYC cycles after its `mem_we_n` rising edge. `req_ready` then stays 0 for exactly TWC_CYC cycles.
- R8: If no byte is taken while the page is open, `mem_ce_n` rises WIN_MAX_CYC-WIN_MARGIN_CYC-TAS_CYC cycles after the last rising edge of `mem_we_n`. No further strobe follows, and the TWC_CYC wait of R7 applies.
- R9: `mem_dq_oe` is 1 at every `mem_we_n` falling edge and 0 whenever `mem_ce_n` is 1. `mem_oe_n` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Host offers a byte |
| req_addr | input | AW | Byte address |
| req_data | input | DW | Byte value |
| req_last | input | 1 | Offered byte closes the page |
| req_ready | output | 1 | Sequencer will take a byte this cycle |
| busy | output | 1 | Inhibit, page or write cycle in progress |
| mem_addr | output | AW | Memory address bus |
| mem_dq | output | DW | Memory data bus, output value |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
The hardest case to reach is a page that stays open until the very last cycle of the window. The host must deliver its next byte in exactly the cycle where the window timer reaches zero, so that acceptance wins over the timeout. The stimulus table holds one byte back for a precise number of cycles after `req_ready` appears, which lands the strobe spacing exactly on the upper limit. A later page is then abandoned on purpose to force the timeout commit. During that commit a request is injected and must be dropped.

// File: rtl/eep_pw_pkg.sv
package eep_pw_pkg;

   typedef enum logic [2:0] {
      ST_INHIBIT,
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_GAP,
      ST_COMMIT
   } pw_state_e;

   function automatic int pw_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int pw_ceil(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/eep_pw_timer.sv
module eep_pw_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (en && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/eep_pw_bus.sv
module eep_pw_bus #(
   parameter int AW        = 13,
   parameter int DW        = 8,
   parameter bit PARK_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          ce_n_in,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (cap) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   // output enable of the memory is never asserted, so the bus may be
   // driven whenever the chip is selected
   assign dq_oe_o = !ce_n_in;

   generate
      if (PARK_IDLE) begin : g_park
         assign addr_o = ce_n_in ? '0 : addr_q;
         assign dq_o   = ce_n_in ? '0 : data_q;
      end else begin : g_hold
         assign addr_o = addr_q;
         assign dq_o   = data_q;
      end
   endgenerate

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
   import eep_pw_pkg::*;
#(
   parameter int AW             = 13,
   parameter int DW             = 8,
   parameter int CLK_NS         = 20,
   parameter int GRADE          = 0,
   parameter int TAS_CYC        = 1,
   parameter int TWP_CYC        = 8,
   parameter int TAH_CYC        = 5,
   parameter int TDS_CYC        = 5,
   parameter int THOLD_CYC      = 1,
   parameter int BLC_MIN_CYC    = 3,
   parameter int WIN_MAX_CYC    = 5000,
   parameter int WIN_MARGIN_CYC = 500,
   parameter int TWC_CYC        = 250000,
   parameter int TINH_CYC       = 500000,
   parameter bit PARK_IDLE      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_last,
   output logic          req_ready,
   output logic          busy,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq,
   output logic          mem_dq_oe,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n
);

   localparam int WP_NS     = (GRADE == 0) ? 110 : 150;
   localparam int DS_NS     = (GRADE == 0) ? 60 : 100;
   localparam int AH_NS     = 100;
   localparam int MIN_WP    = pw_ceil(WP_NS, CLK_NS);
   localparam int MIN_DS    = pw_ceil(DS_NS, CLK_NS);
   localparam int MIN_AH    = pw_ceil(AH_NS, CLK_NS);
   localparam int GAP_LIMIT = WIN_MAX_CYC - WIN_MARGIN_CYC - THOLD_CYC - TAS_CYC;
   localparam int GAP_MIN   = pw_max(0, BLC_MIN_CYC - THOLD_CYC - TAS_CYC);
   localparam int MAXD      = pw_max(pw_max(TINH_CYC, TWC_CYC),
                                     pw_max(GAP_LIMIT, pw_max(TWP_CYC, pw_max(TAS_CYC, THOLD_CYC))));
   localparam int CW        = $clog2(MAXD + 1);
   localparam int WW        = pw_max(1, $clog2(GAP_LIMIT + 1));

   localparam logic [CW-1:0] LD_AS   = CW'(TAS_CYC - 1);
   localparam logic [CW-1:0] LD_WP   = CW'(TWP_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD = CW'(THOLD_CYC - 1);
   localparam logic [CW-1:0] LD_WC   = CW'(TWC_CYC - 1);
   localparam logic [WW-1:0] LD_WIN  = WW'(GAP_LIMIT - 1);
   localparam logic [WW-1:0] RDY_THR = WW'(GAP_LIMIT - 1 - GAP_MIN);

   // elaboration-time parameter checks
   generate
      if (GRADE < 0 || GRADE > 1) begin : g_bad_grade
         $error("GRADE must be 0 or 1");
      end
      if (TWP_CYC < MIN_WP || TWP_CYC < TAH_CYC || TWP_CYC < TDS_CYC) begin : g_bad_wp
         $error("TWP_CYC too short for pulse, address hold or data setup");
      end
      if (TAH_CYC < MIN_AH || TDS_CYC < MIN_DS) begin : g_bad_ahds
         $error("TAH_CYC or TDS_CYC below the grade minimum");
      end
      if (TAS_CYC < 1 || THOLD_CYC < 1) begin : g_bad_edge
         $error("setup and hold need at least one cycle");
      end
      if (GAP_LIMIT < GAP_MIN + 1) begin : g_bad_win
         $error("byte-load window too small for the margin");
      end
      if (TINH_CYC < TWC_CYC || TWC_CYC < 1) begin : g_bad_wc
         $error("inhibit period must cover one write cycle");
      end
   endgenerate

   pw_state_e      st, nxt;
   logic           accept, last_q;
   logic           ph_load, ph_zero, win_load, win_zero;
   logic [CW-1:0]  ph_val, ph_cnt;
   logic [WW-1:0]  win_cnt;
   logic           ce_n_q, we_n_q;

   assign req_ready = (st == ST_IDLE) || ((st == ST_GAP) && (win_cnt <= RDY_THR));
   assign accept    = req_start && req_ready;
   assign busy      = (st != ST_IDLE);

   always_comb begin
      nxt      = st;
      ph_val   = '0;
      win_load = 1'b0;
      unique case (st)
         ST_INHIBIT: if (ph_zero) nxt = ST_IDLE;
         ST_IDLE: if (accept) begin
            nxt    = ST_SETUP;
            ph_val = LD_AS;
         end
         ST_SETUP: if (ph_zero) begin
            nxt    = ST_PULSE;
            ph_val = LD_WP;
         end
         ST_PULSE: if (ph_zero) begin
            nxt    = ST_HOLD;
            ph_val = LD_HOLD;
         end
         ST_HOLD: if (ph_zero) begin
            if (last_q) begin
               nxt    = ST_COMMIT;
               ph_val = LD_WC;
            end else begin
               nxt      = ST_GAP;
               win_load = 1'b1;
            end
         end
         ST_GAP: begin
            if (accept) begin
               nxt    = ST_SETUP;
               ph_val = LD_AS;
            end else if (win_zero) begin
               nxt    = ST_COMMIT;
               ph_val = LD_WC;
            end
         end
         ST_COMMIT: if (ph_zero) nxt = ST_IDLE;
         default: nxt = ST_INHIBIT;
      endcase
   end

   assign ph_load = (nxt != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_INHIBIT;
         last_q <= 1'b0;
         ce_n_q <= 1'b1;
         we_n_q <= 1'b1;
      end else begin
         st     <= nxt;
         if (accept) last_q <= req_last;
         we_n_q <= (nxt != ST_PULSE);
         ce_n_q <= !((nxt == ST_SETUP) || (nxt == ST_PULSE) ||
                     (nxt == ST_HOLD)  || (nxt == ST_GAP));
      end
   end

   eep_pw_timer #(.W(CW), .RST_VAL(TINH_CYC - 1)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .en       (1'b1),
      .cnt      (ph_cnt),
      .zero     (ph_zero)
   );

   eep_pw_timer #(.W(WW), .RST_VAL(0)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_load),
      .load_val (LD_WIN),
      .en       (st == ST_GAP),
      .cnt      (win_cnt),
      .zero     (win_zero)
   );

   eep_pw_bus #(.AW(AW), .DW(DW), .PARK_IDLE(PARK_IDLE)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (accept),
      .addr_in (req_addr),
      .data_in (req_data),
      .ce_n_in (ce_n_q),
      .addr_o  (mem_addr),
      .dq_o    (mem_dq),
      .dq_oe_o (mem_dq_oe)
   );

   assign mem_ce_n = ce_n_q;
   assign mem_we_n = we_n_q;
   assign mem_oe_n = 1'b1;

endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk #(
   parameter int AW             = 13,
   parameter int DW             = 8,
   parameter int TWP_CYC        = 8,
   parameter int WIN_MAX_CYC    = 5000,
   parameter int WIN_MARGIN_CYC = 500,
   parameter int TWC_CYC        = 250000,
   parameter int TINH_CYC       = 500000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_dq,
   input logic          mem_dq_oe,
   input logic          mem_ce_n,
   input logic          mem_we_n
);

   logic [31:0] low_cnt, rf_cnt, wc_cnt, inh_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         rf_cnt  <= '0;
         wc_cnt  <= '0;
         inh_cnt <= '0;
      end else begin
         low_cnt <= mem_we_n ? '0 : low_cnt + 1;
         if (!mem_we_n || mem_ce_n) rf_cnt <= '0;
         else if (rf_cnt < 32'(WIN_MAX_CYC)) rf_cnt <= rf_cnt + 1;
         if (!mem_ce_n) wc_cnt <= '0;
         else if (wc_cnt < 32'(TWC_CYC)) wc_cnt <= wc_cnt + 1;
         if (inh_cnt < 32'(TINH_CYC)) inh_cnt <= inh_cnt + 1;
      end
   end

   AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_cnt < 32'(TINH_CYC)) |-> (mem_ce_n && !req_ready)); // R1

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_cnt == 32'(TWP_CYC))); // R3

   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq))); // R4

   AST_WINDOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (rf_cnt <= 32'(WIN_MAX_CYC - WIN_MARGIN_CYC))); // R5

   AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n); // R6

   AST_COMMIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce_n && (wc_cnt < 32'(TWC_CYC))) |-> !req_ready); // R7

   AST_DQ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> mem_dq_oe); // R9

endmodule

bind eep_page_writer eep_page_writer_chk #(
   .AW(AW), .DW(DW), .TWP_CYC(TWP_CYC), .WIN_MAX_CYC(WIN_MAX_CYC),
   .WIN_MARGIN_CYC(WIN_MARGIN_CYC), .TWC_CYC(TWC_CYC), .TINH_CYC(TINH_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
   .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n)
);

// File: tb/sim_eep_page_writer.sv
module sim_eep_page_writer;

   localparam int AW = 13, DW = 8;
   localparam int TAS = 1, TWP = 6, TAH = 5, TDS = 3, THOLD = 1, BLC = 3;
   localparam int WIN = 30, MARGIN = 5, TWC = 40, TINH = 50;
   localparam int TO_GAP = WIN - MARGIN - TAS;   // 24
   localparam int NV = 6;
   // {addr, data, last, stall cycles after ready}
   localparam logic [29:0] VEC [NV] = '{
      {13'h0100, 8'hA5, 1'b0, 8'd0},
      {13'h0101, 8'h5A, 1'b0, 8'd5},
      {13'h0102, 8'h3C, 1'b1, 8'd0},
      {13'h1FFF, 8'hFF, 1'b1, 8'd0},
      {13'h0000, 8'h00, 1'b0, 8'd0},
      {13'h0ABC, 8'h81, 1'b1, 8'd21}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_start = 1'b0, req_last = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic req_ready, busy, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq;

   always #10 clk = ~clk;

   eep_page_writer #(
      .AW(AW), .DW(DW), .CLK_NS(20), .GRADE(0), .TAS_CYC(TAS), .TWP_CYC(TWP),
      .TAH_CYC(TAH), .TDS_CYC(TDS), .THOLD_CYC(THOLD), .BLC_MIN_CYC(BLC),
      .WIN_MAX_CYC(WIN), .WIN_MARGIN_CYC(MARGIN), .TWC_CYC(TWC), .TINH_CYC(TINH)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_data(req_data), .req_last(req_last), .req_ready(req_ready), .busy(busy),
      .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   int n_chk = 0, n_bad = 0, wd = 0;
   bit done = 1'b0, mon_en = 1'b0;
   logic [AW-1:0] exp_a [16];
   logic [DW-1:0] exp_d [16];
   int wi = 0, ri = 0, strobes = 0, exp_cgap = 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit last, input int stall);
      while (!req_ready) @(negedge clk);
      repeat (stall) @(negedge clk);
      exp_a[wi] = a; exp_d[wi] = d; wi++;
      exp_cgap = last ? THOLD : TO_GAP;
      req_addr = a; req_data = d; req_last = last; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   // port monitor, sampled away from the active edge
   bit prev_we = 1'b1, prev_ce = 1'b1, in_page = 1'b0, committing = 1'b0;
   int since_rise = 1000, low_cnt = 0, ce_cnt = 0;
   logic [AW-1:0] f_addr;
   logic [DW-1:0] f_dq;

   always @(negedge clk) begin
      if (mon_en) begin
         if (!prev_we && mem_we_n) begin
            chk(low_cnt == TWP, "R3 pulse width", low_cnt, TWP);
            chk(mem_addr == exp_a[ri] && mem_dq == exp_d[ri], "R3 strobe addr/data",
                int'({mem_addr, mem_dq}), int'({exp_a[ri], exp_d[ri]}));
            ri++; strobes++; since_rise = 0; in_page = 1'b1;
         end else if (since_rise < 1000) begin
            since_rise++;
         end
         if (prev_we && !mem_we_n) begin
            chk(!mem_ce_n, "R6 chip enable low at strobe", int'(mem_ce_n), 0);
            chk(mem_dq_oe, "R9 bus driven at strobe", int'(mem_dq_oe), 1);
            if (in_page)
               chk(since_rise >= BLC && since_rise <= WIN - MARGIN,
                   "R5 strobe spacing", since_rise, WIN - MARGIN);
            low_cnt = 1; f_addr = mem_addr; f_dq = mem_dq;
         end else if (!mem_we_n) begin
            low_cnt++;
            chk(mem_addr == f_addr && mem_dq == f_dq, "R4 bus stable in pulse",
                int'({mem_addr, mem_dq}), int'({f_addr, f_dq}));
         end
         if (since_rise == 1)
            chk(!req_ready, "R5 ready held after rise", int'(req_ready), 0);
         if (since_rise == 2 && !mem_ce_n)
            chk(req_ready, "R5 ready offered in open page", int'(req_ready), 1);
         if (!prev_ce && mem_ce_n) begin
            chk(since_rise == exp_cgap, (exp_cgap == THOLD) ? "R7 close after last" :
                "R8 close on timeout", since_rise, exp_cgap);
            ce_cnt = 1; committing = 1'b1; in_page = 1'b0;
         end else if (committing) begin
            if (!req_ready) ce_cnt++;
            else begin
               chk(ce_cnt == TWC, "R7 write-cycle wait", ce_cnt, TWC);
               committing = 1'b0;
            end
         end
         if (mem_ce_n)
            chk(!mem_dq_oe && mem_oe_n, "R9 bus released, OE# high",
                int'({mem_dq_oe, mem_oe_n}), 1);
         prev_we = mem_we_n; prev_ce = mem_ce_n;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
            finish_run();
         end
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk(!req_ready && busy && mem_ce_n && mem_we_n && mem_oe_n,
          "R1 state in reset", int'({req_ready, busy, mem_ce_n, mem_we_n}), 4'b0111);
      rst_n = 1'b1;
      mon_en = 1'b1;
      chk(!req_ready && busy && mem_ce_n && mem_we_n && !mem_dq_oe,
          "R1 state after release", int'({req_ready, busy, mem_ce_n, mem_we_n}), 4'b0111);
      // request during inhibit must be dropped
      req_addr = 13'h0555; req_data = 8'h99; req_start = 1'b1;
      n = 0;
      @(negedge clk); n++;
      req_start = 1'b0;
      while (!req_ready && n < 1000) begin
         @(negedge clk); n++;
      end
      chk(n == TINH, "R1 inhibit length", n, TINH);
      repeat (5) @(negedge clk);
      chk(strobes == 0 && mem_ce_n, "R2 start in inhibit ignored", strobes, 0);

      // table-driven pages
      for (int i = 0; i < NV; i++)
         send(VEC[i][29:17], VEC[i][16:9], VEC[i][8], int'(VEC[i][7:0]));
      while (busy) @(negedge clk);
      chk(strobes == NV, "R3 one strobe per byte", strobes, NV);

      // abandoned page: timeout commit
      send(13'h0200, 8'h11, 1'b0, 0);
      send(13'h0201, 8'h22, 1'b0, 0);
      while (!(mem_ce_n && !req_ready)) @(negedge clk);
      // request during write cycle must be dropped
      req_addr = 13'h0777; req_data = 8'h66; req_last = 1'b1; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (!req_ready) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(strobes == NV + 2, "R8 no strobe after timeout", strobes, NV + 2);
      chk(ri == wi, "R2 start in write cycle ignored", ri, wi);
      chk(!busy && req_ready && mem_ce_n && mem_we_n, "R2 idle after drop",
          int'({busy, req_ready, mem_ce_n, mem_we_n}), 4'b0111);
      finish_run();
   end

endmodule